// File: doc/BRIEF.md
# Floating-Point Control Register Access Gate

This block decides whether a system-register move to or from the floating-point control register may go ahead. It first compares the five-field system encoding of the request with the encoding of that register. It then weighs the current privilege level against the access-enable and trap controls that the higher privilege levels own, and returns one verdict: allow, undefined, or trap to a named level with a syndrome code. The decision logic is combinational. The verdict is held in a register, so it appears one clock after the request.

The request is judged the same way for reads and for writes. The direction bit only drives a write-enable strobe, and only when the verdict is allow and the encoding matched. A core places the gate beside its system-register file and routes a trap or undefined verdict into its exception entry logic. That exception logic, and the register storage itself, are outside this block.

Top module: `fpctl_access_gate`

## Requirements
- R1: The request matches only when op0=2'b11, op1=3'b011, CRn=4'b0100, CRm=4'b0100 and op2=3'b000. On any other encoding the response has hit=0, kind allow, target 0, syndrome 0 and no write-enable.
- R2: Each request taken on req_valid gives a response one clock later. In that response rsp_valid=1 and kind is 0 for allow, 1 for undefined, or 2 for trap. The trap syndrome is 6'h07, except for the one case in R5. When the kind is not trap, target and syndrome are 0. When no request is given, all outputs are 0 in the next cycle.
- R3: At levels 0, 1 and 2 the verdict is undefined when all of these hold: halted, level 3 present, secure-debug-disable set, the HALT_L3_PRIO parameter set, and the level-3 trap bit set. This check outranks every other check.
- R4: At level 3 the access traps to level 3 with 0x07 when the level-3 trap bit is 1, and is allowed otherwise. Debug state has no effect at level 3.
- R5: At level 0 a trap occurs when the level-1 enable field is not 2'b11 and the pair (level 2 active, host and trap-general both 1) is not true. That trap goes to level 2 with syndrome 0x00 when level 2 is active and trap-general is 1. Otherwise it goes to level 1 with 0x07.
- R6: At level 0, when level 2 is active and host and trap-general are both 1, a level-2 enable field other than 2'b11 traps to level 2 with 0x07. The level-1 field is then ignored.
- R7: At level 1 a level-1 enable field with bit 0 clear traps to level 1 with 0x07. This comes before all level-2 checks.
- R8: At levels 0 and 1, with level 2 active, a set level-2 trap bit traps to level 2 with 0x07 when host is 0. When host is 1, a level-2 enable field with bit 0 clear does the same. At level 2 the same two tests apply without needing level 2 active. They do nothing when level 2 is inactive at levels 0 and 1.
- R9: At levels 0 to 2, when no earlier check fires, level 3 is present and the level-3 trap bit is set, the access traps to level 3 with 0x07. If the core is halted with secure-debug-disable set, the verdict is undefined instead.
- R10: rsp_wr_en is 1 only for a matching write whose verdict is allow.
- R11: A synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a move into the register, 0 for a read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field CRn |
| req_crm | input | 4 | Encoding field CRm |
| req_op2 | input | 3 | Encoding field op2 |
| req_priv | input | 2 | Current privilege level, 0 to 3 |
| dbg_halted | input | 1 | Core is in halted debug state |
| dbg_sdd | input | 1 | Secure-debug-disable |
| l3_present | input | 1 | Level 3 is implemented |
| l2_active | input | 1 | Level 2 is enabled |
| l1_fp_en | input | 2 | Level-1 floating-point access-enable field |
| l2_fp_en | input | 2 | Level-2 floating-point access-enable field |
| l2_fp_trap | input | 1 | Level-2 floating-point trap bit |
| l2_host | input | 1 | Level-2 host-mode bit |
| l2_tgen | input | 1 | Level-2 trap-general bit |
| l3_fp_trap | input | 1 | Level-3 floating-point trap bit |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Encoding matched |
| rsp_kind | output | 2 | 0 allow, 1 undefined, 2 trap |
| rsp_tgt | output | 2 | Trap target level |
| rsp_syn | output | 6 | Trap syndrome code |
| rsp_wr_en | output | 1 | Write strobe to the register |

## Verification
Directed requests are sent at each privilege level. Each one sets a single control so that it alone decides the verdict, and a second control is often set as well to show which of the two wins, for example a debug undefined against a level-1 trap, or a host-mode level-2 check against a cleared level-1 field. The level-0 cases with trap-general set show apart the two trap targets and the two syndrome codes. Requests with one wrong encoding field show apart a miss from an allowed access. A long random sweep then covers all of the control fields, both directions, and mostly matching encodings, and each response is compared against a behavioural model.

// File: rtl/fpag_pkg.sv
package fpag_pkg;
  parameter int PRIV_W = 2;
  parameter int SYN_W  = 6;
  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    RES_ALLOW = 2'd0,
    RES_UNDEF = 2'd1,
    RES_TRAP  = 2'd2
  } res_kind_e;

  localparam logic [SYN_W-1:0] SYN_FPACC = 6'h07;
  localparam logic [SYN_W-1:0] SYN_GEN   = 6'h00;

  typedef struct packed {
    logic       halted;
    logic       sdd;
    logic       has_l3;
    logic       l2_on;
    logic [1:0] l1_en;
    logic [1:0] l2_en;
    logic       l2_trap;
    logic       host;
    logic       tgen;
    logic       l3_trap;
  } ctl_t;
endpackage

// File: rtl/fpag_enc_match.sv
module fpag_enc_match #(
  parameter logic [1:0] M_OP0 = 2'b11,
  parameter logic [2:0] M_OP1 = 3'b011,
  parameter logic [3:0] M_CRN = 4'b0100,
  parameter logic [3:0] M_CRM = 4'b0100,
  parameter logic [2:0] M_OP2 = 3'b000
) (
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit
);
  always_comb begin
    hit = (op0 == M_OP0) && (op1 == M_OP1) && (crn == M_CRN) &&
          (crm == M_CRM) && (op2 == M_OP2);
  end
endmodule

// File: rtl/fpag_lower_chk.sv
module fpag_lower_chk
  import fpag_pkg::*;
(
  input  logic [PRIV_W-1:0] priv,
  input  ctl_t              ctl,
  output logic              trap,
  output logic [PRIV_W-1:0] tgt,
  output logic [SYN_W-1:0]  syn
);
  logic l2_guard_host;
  logic l2_guard_plain;

  always_comb begin
    l2_guard_host  = ctl.host && !ctl.l2_en[0];
    l2_guard_plain = !ctl.host && ctl.l2_trap;
  end

  always_comb begin
    trap = 1'b0;
    tgt  = '0;
    syn  = '0;
    case (priv)
      2'd0: begin
        if (!(ctl.l2_on && ctl.host && ctl.tgen) && ctl.l1_en != 2'b11) begin
          trap = 1'b1;
          if (ctl.l2_on && ctl.tgen) begin
            tgt = 2'd2;
            syn = SYN_GEN;
          end else begin
            tgt = 2'd1;
            syn = SYN_FPACC;
          end
        end else if (ctl.l2_on && ctl.host && ctl.tgen && ctl.l2_en != 2'b11) begin
          trap = 1'b1; tgt = 2'd2; syn = SYN_FPACC;
        end else if (ctl.l2_on && (l2_guard_host || l2_guard_plain)) begin
          trap = 1'b1; tgt = 2'd2; syn = SYN_FPACC;
        end
      end
      2'd1: begin
        if (!ctl.l1_en[0]) begin
          trap = 1'b1; tgt = 2'd1; syn = SYN_FPACC;
        end else if (ctl.l2_on && (l2_guard_host || l2_guard_plain)) begin
          trap = 1'b1; tgt = 2'd2; syn = SYN_FPACC;
        end
      end
      2'd2: begin
        if (l2_guard_host || l2_guard_plain) begin
          trap = 1'b1; tgt = 2'd2; syn = SYN_FPACC;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fpag_upper_chk.sv
module fpag_upper_chk
  import fpag_pkg::*;
#(
  parameter logic HALT_L3_PRIO = 1'b1
) (
  input  logic [PRIV_W-1:0] priv,
  input  ctl_t              ctl,
  output logic              top_lvl,
  output logic              pre_undef,
  output logic              l3_hit,
  output logic              l3_undef
);
  logic dbg_lock;

  always_comb begin
    dbg_lock  = ctl.halted && ctl.sdd;
    top_lvl   = (priv == 2'd3);
    pre_undef = !top_lvl && HALT_L3_PRIO && dbg_lock && ctl.has_l3 && ctl.l3_trap;
    l3_hit    = top_lvl ? ctl.l3_trap : (ctl.has_l3 && ctl.l3_trap);
    l3_undef  = !top_lvl && dbg_lock;
  end
endmodule

// File: rtl/fpctl_access_gate.sv
module fpctl_access_gate
  import fpag_pkg::*;
#(
  parameter logic [1:0] M_OP0        = 2'b11,
  parameter logic [2:0] M_OP1        = 3'b011,
  parameter logic [3:0] M_CRN        = 4'b0100,
  parameter logic [3:0] M_CRM        = 4'b0100,
  parameter logic [2:0] M_OP2        = 3'b000,
  parameter logic       HALT_L3_PRIO = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_op0,
  input  logic [2:0]        req_op1,
  input  logic [3:0]        req_crn,
  input  logic [3:0]        req_crm,
  input  logic [2:0]        req_op2,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic              dbg_halted,
  input  logic              dbg_sdd,
  input  logic              l3_present,
  input  logic              l2_active,
  input  logic [1:0]        l1_fp_en,
  input  logic [1:0]        l2_fp_en,
  input  logic              l2_fp_trap,
  input  logic              l2_host,
  input  logic              l2_tgen,
  input  logic              l3_fp_trap,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [KIND_W-1:0] rsp_kind,
  output logic [PRIV_W-1:0] rsp_tgt,
  output logic [SYN_W-1:0]  rsp_syn,
  output logic              rsp_wr_en
);
  ctl_t              ctl;
  logic              enc_hit;
  logic              lo_trap;
  logic [PRIV_W-1:0] lo_tgt;
  logic [SYN_W-1:0]  lo_syn;
  logic              top_lvl, pre_undef, l3_hit, l3_undef;
  res_kind_e         nx_kind;
  logic [PRIV_W-1:0] nx_tgt;
  logic [SYN_W-1:0]  nx_syn;

  always_comb begin
    ctl.halted  = dbg_halted;
    ctl.sdd     = dbg_sdd;
    ctl.has_l3  = l3_present;
    ctl.l2_on   = l2_active;
    ctl.l1_en   = l1_fp_en;
    ctl.l2_en   = l2_fp_en;
    ctl.l2_trap = l2_fp_trap;
    ctl.host    = l2_host;
    ctl.tgen    = l2_tgen;
    ctl.l3_trap = l3_fp_trap;
  end

  fpag_enc_match #(
    .M_OP0(M_OP0), .M_OP1(M_OP1), .M_CRN(M_CRN), .M_CRM(M_CRM), .M_OP2(M_OP2)
  ) u_enc (
    .op0(req_op0), .op1(req_op1), .crn(req_crn), .crm(req_crm), .op2(req_op2),
    .hit(enc_hit)
  );

  fpag_lower_chk u_lower (
    .priv(req_priv), .ctl(ctl), .trap(lo_trap), .tgt(lo_tgt), .syn(lo_syn)
  );

  fpag_upper_chk #(.HALT_L3_PRIO(HALT_L3_PRIO)) u_upper (
    .priv(req_priv), .ctl(ctl), .top_lvl(top_lvl), .pre_undef(pre_undef),
    .l3_hit(l3_hit), .l3_undef(l3_undef)
  );

  // Priority: debug undefined, lower-level traps, level-3 trap, allow.
  always_comb begin
    nx_kind = RES_ALLOW;
    nx_tgt  = '0;
    nx_syn  = '0;
    if (!enc_hit) begin
      nx_kind = RES_ALLOW;
    end else if (pre_undef) begin
      nx_kind = RES_UNDEF;
    end else if (!top_lvl && lo_trap) begin
      nx_kind = RES_TRAP;
      nx_tgt  = lo_tgt;
      nx_syn  = lo_syn;
    end else if (l3_hit && l3_undef) begin
      nx_kind = RES_UNDEF;
    end else if (l3_hit) begin
      nx_kind = RES_TRAP;
      nx_tgt  = 2'd3;
      nx_syn  = SYN_FPACC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_kind  <= RES_ALLOW;
      rsp_tgt   <= '0;
      rsp_syn   <= '0;
      rsp_wr_en <= 1'b0;
    end else begin
      rsp_valid <= 1'b1;
      rsp_hit   <= enc_hit;
      rsp_kind  <= nx_kind;
      rsp_tgt   <= nx_tgt;
      rsp_syn   <= nx_syn;
      rsp_wr_en <= req_write && enc_hit && (nx_kind == RES_ALLOW);
    end
  end

  AST_MISS_ALLOWS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !enc_hit) |=> (rsp_kind == RES_ALLOW && !rsp_wr_en)); // R1
  AST_TRAP_UPWARD: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RES_TRAP) |-> (rsp_tgt != 2'd0 && rsp_tgt >= $past(req_priv))); // R2
  AST_UNDEF_NEEDS_HALT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !dbg_halted) |=> (rsp_kind != RES_UNDEF)); // R3
  AST_TOP_NO_UNDEF: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_priv == 2'd3) |=> (rsp_kind != RES_UNDEF)); // R4
  AST_GEN_SYN_TO_L2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_kind == RES_TRAP && rsp_syn == SYN_GEN) |-> (rsp_tgt == 2'd2)); // R5
  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> !rsp_wr_en); // R10
endmodule

// File: tb/sim_fpctl_access_gate.sv
module sim_fpctl_access_gate;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_op0 = 2'b11;
  logic [2:0] req_op1 = 3'b011;
  logic [3:0] req_crn = 4'b0100, req_crm = 4'b0100;
  logic [2:0] req_op2 = 3'b000;
  logic [1:0] req_priv = 2'd0;
  logic dbg_halted = 0, dbg_sdd = 0, l3_present = 0, l2_active = 0;
  logic [1:0] l1_fp_en = 2'b11, l2_fp_en = 2'b11;
  logic l2_fp_trap = 0, l2_host = 0, l2_tgen = 0, l3_fp_trap = 0;
  logic       rsp_valid, rsp_hit, rsp_wr_en;
  logic [1:0] rsp_kind, rsp_tgt;
  logic [5:0] rsp_syn;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fpctl_access_gate u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_op0(req_op0), .req_op1(req_op1), .req_crn(req_crn), .req_crm(req_crm),
    .req_op2(req_op2), .req_priv(req_priv), .dbg_halted(dbg_halted),
    .dbg_sdd(dbg_sdd), .l3_present(l3_present), .l2_active(l2_active),
    .l1_fp_en(l1_fp_en), .l2_fp_en(l2_fp_en), .l2_fp_trap(l2_fp_trap),
    .l2_host(l2_host), .l2_tgen(l2_tgen), .l3_fp_trap(l3_fp_trap),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_kind(rsp_kind),
    .rsp_tgt(rsp_tgt), .rsp_syn(rsp_syn), .rsp_wr_en(rsp_wr_en)
  );

  // Behavioural model: {valid, hit, kind, tgt, syn, wr}
  function automatic logic [12:0] model(output string rq);
    int lvl, kind, tgt, syn;
    bit hit, lock, wr;
    lvl = int'(req_priv);
    kind = 0; tgt = 0; syn = 0;
    hit = (req_op0 == 2'b11 && req_op1 == 3'b011 && req_crn == 4'd4 &&
           req_crm == 4'd4 && req_op2 == 3'd0);
    lock = dbg_halted && dbg_sdd;
    rq = "R2";
    if (!req_valid) return 13'd0;
    if (!hit) rq = "R1";
    else if (lvl == 3) begin
      rq = "R4";
      if (l3_fp_trap) begin kind = 2; tgt = 3; syn = 7; end
    end else if (lock && l3_present && l3_fp_trap) begin
      rq = "R3"; kind = 1;
    end else begin
      if (lvl == 0 && !(l2_active && l2_host && l2_tgen) && l1_fp_en != 2'b11) begin
        rq = "R5"; kind = 2;
        if (l2_active && l2_tgen) begin tgt = 2; syn = 0; end
        else begin tgt = 1; syn = 7; end
      end else if (lvl == 0 && l2_active && l2_host && l2_tgen && l2_fp_en != 2'b11) begin
        rq = "R6"; kind = 2; tgt = 2; syn = 7;
      end else if (lvl == 1 && l1_fp_en[0] == 1'b0) begin
        rq = "R7"; kind = 2; tgt = 1; syn = 7;
      end else if ((lvl == 2 || l2_active) &&
                   ((!l2_host && l2_fp_trap) || (l2_host && !l2_fp_en[0]))) begin
        rq = "R8"; kind = 2; tgt = 2; syn = 7;
      end else if (l3_present && l3_fp_trap) begin
        rq = "R9";
        if (lock) kind = 1;
        else begin kind = 2; tgt = 3; syn = 7; end
      end
    end
    wr = req_write && hit && kind == 0;
    if (wr) rq = "R10";
    return {1'b1, hit, 2'(kind), 2'(tgt), 6'(syn), wr};
  endfunction

  task automatic step();
    string rq;
    logic [12:0] exp;
    logic [12:0] act;
    exp = model(rq);
    if (rst) begin exp = 13'd0; rq = "R11"; end
    @(posedge clk);
    #1;
    act = {rsp_valid, rsp_hit, rsp_kind, rsp_tgt, rsp_syn, rsp_wr_en};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (lvl %0d)", rq, act, exp, req_priv);
    end
  endtask

  task automatic base(input int lvl);
    req_valid = 1; req_write = 1; req_priv = 2'(lvl);
    req_op0 = 2'b11; req_op1 = 3'b011; req_crn = 4'd4; req_crm = 4'd4; req_op2 = 3'd0;
    dbg_halted = 0; dbg_sdd = 0; l3_present = 1; l2_active = 1;
    l1_fp_en = 2'b11; l2_fp_en = 2'b11; l2_fp_trap = 0; l2_host = 0; l2_tgen = 0;
    l3_fp_trap = 0;
  endtask

  initial begin
    #1;
    base(0);
    step(); step();                                   // R11 reset holds outputs low
    rst = 0;
    req_valid = 0; step();                            // R2 idle cycle
    base(0); req_crm = 4'd5; step();                  // R1 miss
    base(2); req_op2 = 3'd1; l2_fp_trap = 1; step();  // R1 miss beats trap
    base(3); l3_fp_trap = 1; dbg_halted = 1; dbg_sdd = 1; step(); // R4
    base(3); step();                                  // R4 / R10 allow write
    base(3); req_write = 0; step();                   // R10 read no strobe
    base(1); l1_fp_en = 0; dbg_halted = 1; dbg_sdd = 1; l3_fp_trap = 1; step(); // R3
    base(1); l1_fp_en = 0; dbg_halted = 1; dbg_sdd = 1; l3_fp_trap = 1; l3_present = 0; step(); // R7
    base(0); l1_fp_en = 1; l2_tgen = 1; step();       // R5 to level 2, code 0
    base(0); l1_fp_en = 1; step();                    // R5 to level 1
    base(0); l1_fp_en = 1; l2_tgen = 1; l2_active = 0; step(); // R5 level 2 off
    base(0); l1_fp_en = 0; l2_host = 1; l2_tgen = 1; l2_fp_en = 1; step(); // R6
    base(0); l1_fp_en = 0; l2_host = 1; l2_tgen = 1; step(); // R6 allow
    base(1); l1_fp_en = 2; step();                    // R7
    base(1); l1_fp_en = 1; step();                    // R7 allow
    base(1); l2_fp_trap = 1; step();                  // R8
    base(2); l2_active = 0; l2_fp_trap = 1; step();   // R8 level 2 ignores active
    base(2); l2_host = 1; l2_fp_en = 2; step();       // R8 host pattern
    base(0); l2_active = 0; l2_fp_trap = 1; step();   // R8 ignored when inactive
    base(2); l3_fp_trap = 1; step();                  // R9 trap to 3
    base(1); l3_fp_trap = 1; l3_present = 0; step();  // R9 no level 3
    for (int i = 0; i < 4000; i++) begin
      {req_valid, req_write, req_priv, dbg_halted, dbg_sdd, l3_present, l2_active,
       l1_fp_en, l2_fp_en, l2_fp_trap, l2_host, l2_tgen, l3_fp_trap} = 17'($urandom);
      if (($urandom % 8) == 0) begin
        {req_op0, req_op1, req_crn, req_crm, req_op2} = 16'($urandom);
      end else begin
        req_op0 = 2'b11; req_op1 = 3'b011; req_crn = 4'd4; req_crm = 4'd4; req_op2 = 3'd0;
      end
      if (($urandom % 16) == 0) req_valid = 1;
      step();
    end
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule